// File: doc/BRIEF.md
# Descriptor Ring Transfer Engine

This block moves Ethernet frames between a small internal buffer memory and a byte-wide MAC-side stream, under the control of descriptor rings. The descriptors live in an internal descriptor memory. A host fills that memory, the frame buffer and a handful of control registers through one word-wide register port. Each descriptor takes four consecutive 32-bit words: status, control/size, buffer address and a fourth word that the engine skips. A transmit engine walks one ring and a receive engine walks another. Each engine takes a descriptor only while the ownership bit of its status word is set. When it has finished with the descriptor it writes the status back with that bit cleared.

The host stores descriptors and frame bytes through the port and sets the ring bases. It then starts either direction from the operation-mode register. On transmit, the engine streams the bytes a descriptor points at to the MAC side, with first and last markers, and it suspends at the first descriptor it does not own until the host writes the poll register. On receive, the engine stores the incoming bytes into the buffer a descriptor names. It then writes the frame length and an error summary into the status word. When it meets a descriptor it does not own, it holds the incoming frame back until ownership returns.

Host address map (9-bit word address, bits 8:7 choose the region). Region 0 is the descriptor memory, indexed by word. Region 1 is the frame buffer, one byte per address in the low 8 bits. Region 2 holds the registers, selected by bits 2:0: 0 bus mode, 1 operation mode, 2 transmit poll, 3 receive ring base, 4 transmit ring base, 5 status. Ring bases are descriptor-memory word indices. Buffer addresses are byte indices.

Top module: `dring_dma`

## Requirements
- R1: After hardware reset, and in the cycle after any host write to the bus-mode register with bit 0 set, the status register reads 0 and the operation-mode and both ring-base registers read 0. Descriptor and buffer contents are kept.
- R2: An engine only acts on a descriptor whose status bit 31 is 1. When it finishes that descriptor it writes the status word back with bit 31 cleared.
- R3: For an owned transmit descriptor, the engine sends the number of bytes given in control bits 10:0 on the transmit stream, starting at the buffer address in word 2. It raises the first marker with byte 0 when control bit 29 is set and the last marker with the final byte when control bit 30 is set. While the stream is not ready it holds the byte steady.
- R4: A transmit length of 0, or one larger than the buffer size, sends no byte and writes back a status of 0x00008000 (bit 15 is the error summary).
- R5: A transmit descriptor with control bit 27 set is a setup packet. It sends no byte and writes back a status of 0.
- R6: When the transmit engine meets a descriptor it does not own, it enters the suspended state (code 6). It fetches again only after a host write to the poll register.
- R7: After a descriptor whose control bit 25 is set, an engine continues at its ring base. Otherwise it continues four words further on.
- R8: A received frame is written byte by byte into the buffer. The status write-back holds the frame's total byte count in bits 31:16, bit 8 set, and bit 15 set if the error input came with any byte.
- R9: Bytes beyond the capacity in receive control bits 10:0 are dropped and set bit 15. The length still counts every byte.
- R10: When the receive engine meets a descriptor it does not own, it enters the suspended state (code 4) with rx_ready low. It keeps re-reading the descriptor and accepts the frame once bit 31 becomes 1.
- R11: Operation-mode bit 13 runs the transmit engine and bit 1 runs the receive engine. Starting an engine begins at its ring base. Clearing the bit returns the engine to the stopped state (code 0) at its next descriptor fetch, suspended wait or idle receive wait.
- R12: Status bits 22:20 carry the transmit code (0 stopped, 1 fetching, 2 sending, 3 closing, 6 suspended). Bits 19:17 carry the receive code (0 stopped, 1 fetching, 3 receiving, 5 closing, 4 suspended). All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 9 | Host word address (region in bits 8:7) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr, combinational |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | MAC accepts the transmit byte |
| tx_data | output | 8 | Transmit byte |
| tx_first | output | 1 | First byte of a frame |
| tx_last | output | 1 | Last byte of a frame |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Engine accepts a receive byte |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of the received frame |
| rx_err | input | 1 | Error flag for the received byte |

## Verification
The bench builds the block with its default parameters: 32 descriptor words (eight descriptors), a 128-byte buffer and an 11-bit length field. With these values a length of 200 exceeds the buffer, so the oversize path is reachable. Two-descriptor rings also let wrap, stall and resume all occur within a few dozen cycles. The receive capacity of 2 bytes puts overflow within reach of a three-byte frame.

// File: rtl/dring_pkg.sv
package dring_pkg;

  localparam int OWN_B   = 31;
  localparam int LSEG_B  = 30;
  localparam int FSEG_B  = 29;
  localparam int SETUP_B = 27;
  localparam int EOR_B   = 25;
  localparam int ESUM_B  = 15;
  localparam int RLAST_B = 8;

  localparam logic [1:0] RGN_DESC = 2'd0;
  localparam logic [1:0] RGN_BUF  = 2'd1;
  localparam logic [1:0] RGN_REG  = 2'd2;

  localparam logic [2:0] SEL_BUS  = 3'd0;
  localparam logic [2:0] SEL_OPM  = 3'd1;
  localparam logic [2:0] SEL_POLL = 3'd2;
  localparam logic [2:0] SEL_RXB  = 3'd3;
  localparam logic [2:0] SEL_TXB  = 3'd4;
  localparam logic [2:0] SEL_STAT = 3'd5;

  typedef enum logic [2:0] {
    TX_IDLE, TX_OWN, TX_CTRL, TX_BUFA, TX_SEND, TX_CLOSE, TX_SUSP
  } tx_st_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_OWN, RX_CTRL, RX_BUFA, RX_RECV, RX_CLOSE, RX_SUSP
  } rx_st_e;

  function automatic logic [2:0] tx_code(tx_st_e s);
    case (s)
      TX_OWN, TX_CTRL, TX_BUFA: return 3'd1;
      TX_SEND:                  return 3'd2;
      TX_CLOSE:                 return 3'd3;
      TX_SUSP:                  return 3'd6;
      default:                  return 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] rx_code(rx_st_e s);
    case (s)
      RX_OWN, RX_CTRL, RX_BUFA: return 3'd1;
      RX_RECV:                  return 3'd3;
      RX_CLOSE:                 return 3'd5;
      RX_SUSP:                  return 3'd4;
      default:                  return 3'd0;
    endcase
  endfunction

  function automatic logic [31:0] rx_wb_word(logic [15:0] len, logic err);
    logic [31:0] w;
    w = '0;
    w[31:16] = len;
    w[ESUM_B] = err;
    w[RLAST_B] = 1'b1;
    return w;
  endfunction

  function automatic logic [31:0] tx_wb_word(logic err);
    logic [31:0] w;
    w = '0;
    w[ESUM_B] = err;
    return w;
  endfunction

  function automatic logic [31:0] status_word(logic [2:0] txc, logic [2:0] rxc);
    logic [31:0] w;
    w = '0;
    w[22:20] = txc;
    w[19:17] = rxc;
    return w;
  endfunction

endpackage

// File: rtl/dring_mem.sv
module dring_mem #(
  parameter int DESC_WORDS = 32,
  parameter int BUF_BYTES  = 128,
  localparam int DAW = $clog2(DESC_WORDS),
  localparam int BAW = $clog2(BUF_BYTES)
) (
  input  logic           clk,
  input  logic           h_dwe,
  input  logic [DAW-1:0] h_daddr,
  input  logic [31:0]    h_dwdata,
  output logic [31:0]    h_drdata,
  input  logic           h_bwe,
  input  logic [BAW-1:0] h_baddr,
  input  logic [7:0]     h_bwdata,
  output logic [7:0]     h_brdata,
  input  logic [DAW-1:0] t_daddr,
  output logic [31:0]    t_drdata,
  input  logic           t_dwe,
  input  logic [31:0]    t_dwdata,
  input  logic [BAW-1:0] t_baddr,
  output logic [7:0]     t_brdata,
  input  logic [DAW-1:0] r_daddr,
  output logic [31:0]    r_drdata,
  input  logic           r_dwe,
  input  logic [31:0]    r_dwdata,
  input  logic           r_bwe,
  input  logic [BAW-1:0] r_baddr,
  input  logic [7:0]     r_bwdata
);

  logic [31:0] dmem [DESC_WORDS];
  logic [7:0]  bmem [BUF_BYTES];

  // Later writes win on a shared address: engines override the host.
  always_ff @(posedge clk) begin
    if (h_dwe) dmem[h_daddr] <= h_dwdata;
    if (t_dwe) dmem[t_daddr] <= t_dwdata;
    if (r_dwe) dmem[r_daddr] <= r_dwdata;
    if (h_bwe) bmem[h_baddr] <= h_bwdata;
    if (r_bwe) bmem[r_baddr] <= r_bwdata;
  end

  assign h_drdata = dmem[h_daddr];
  assign t_drdata = dmem[t_daddr];
  assign r_drdata = dmem[r_daddr];
  assign h_brdata = bmem[h_baddr];
  assign t_brdata = bmem[t_baddr];

endmodule

// File: rtl/dring_regs.sv
module dring_regs
  import dring_pkg::*;
#(
  parameter int DAW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [2:0]     sel,
  input  logic [31:0]    wdata,
  input  logic [2:0]     txc,
  input  logic [2:0]     rxc,
  output logic [31:0]    rdata,
  output logic           soft_rst,
  output logic           tx_run,
  output logic           rx_run,
  output logic           tx_poll,
  output logic [DAW-1:0] rx_base,
  output logic [DAW-1:0] tx_base
);

  assign soft_rst = we && (sel == SEL_BUS) && wdata[0];
  assign tx_poll  = we && (sel == SEL_POLL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_run  <= 1'b0;
      rx_run  <= 1'b0;
      rx_base <= '0;
      tx_base <= '0;
    end else if (soft_rst) begin
      tx_run  <= 1'b0;
      rx_run  <= 1'b0;
      rx_base <= '0;
      tx_base <= '0;
    end else if (we) begin
      case (sel)
        SEL_OPM: begin
          tx_run <= wdata[13];
          rx_run <= wdata[1];
        end
        SEL_RXB: rx_base <= wdata[DAW-1:0];
        SEL_TXB: tx_base <= wdata[DAW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_OPM:  begin rdata[13] = tx_run; rdata[1] = rx_run; end
      SEL_RXB:  rdata[DAW-1:0] = rx_base;
      SEL_TXB:  rdata[DAW-1:0] = tx_base;
      SEL_STAT: rdata = status_word(txc, rxc);
      default:  ;
    endcase
  end

endmodule

// File: rtl/dring_tx.sv
module dring_tx
  import dring_pkg::*;
#(
  parameter int DAW       = 5,
  parameter int BAW       = 7,
  parameter int LEN_W     = 11,
  parameter int BUF_BYTES = 128
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_rst,
  input  logic           run,
  input  logic           poll,
  input  logic [DAW-1:0] base,
  output logic [DAW-1:0] d_addr,
  input  logic [31:0]    d_rdata,
  output logic           d_we,
  output logic [31:0]    d_wdata,
  output logic [BAW-1:0] b_addr,
  input  logic [7:0]     b_rdata,
  output logic           tx_valid,
  input  logic           tx_ready,
  output logic [7:0]     tx_data,
  output logic           tx_first,
  output logic           tx_last,
  output logic [2:0]     code
);

  tx_st_e           st;
  logic [DAW-1:0]   cur;
  logic [31:0]      ctrl;
  logic [BAW-1:0]   baddr;
  logic [LEN_W-1:0] cnt;
  logic             err;
  logic [LEN_W-1:0] len;
  logic             at_end;

  function automatic logic len_bad(logic [LEN_W-1:0] l);
    return (l == '0) || (int'(l) > BUF_BYTES);
  endfunction

  assign len    = ctrl[LEN_W-1:0];
  assign at_end = (cnt == len - LEN_W'(1));
  assign code   = tx_code(st);

  always_comb begin
    case (st)
      TX_CTRL: d_addr = cur + DAW'(1);
      TX_BUFA: d_addr = cur + DAW'(2);
      default: d_addr = cur;
    endcase
  end

  assign d_we     = (st == TX_CLOSE);
  assign d_wdata  = tx_wb_word(err);
  assign b_addr   = baddr + BAW'(cnt);
  assign tx_valid = (st == TX_SEND);
  assign tx_data  = b_rdata;
  assign tx_first = tx_valid && ctrl[FSEG_B] && (cnt == '0);
  assign tx_last  = tx_valid && ctrl[LSEG_B] && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= TX_IDLE; cur <= '0; ctrl <= '0; baddr <= '0; cnt <= '0; err <= 1'b0;
    end else if (soft_rst) begin
      st <= TX_IDLE; cur <= '0; ctrl <= '0; baddr <= '0; cnt <= '0; err <= 1'b0;
    end else begin
      case (st)
        TX_IDLE: if (run) begin st <= TX_OWN; cur <= base; end
        TX_OWN: begin
          if (!run) st <= TX_IDLE;
          else if (!d_rdata[OWN_B]) st <= TX_SUSP;
          else st <= TX_CTRL;
        end
        TX_CTRL: begin ctrl <= d_rdata; st <= TX_BUFA; end
        TX_BUFA: begin
          baddr <= d_rdata[BAW-1:0];
          cnt   <= '0;
          if (ctrl[SETUP_B]) begin err <= 1'b0; st <= TX_CLOSE; end
          else if (len_bad(len)) begin err <= 1'b1; st <= TX_CLOSE; end
          else begin err <= 1'b0; st <= TX_SEND; end
        end
        TX_SEND: if (tx_ready) begin
          cnt <= cnt + LEN_W'(1);
          if (at_end) st <= TX_CLOSE;
        end
        TX_CLOSE: begin
          cur <= ctrl[EOR_B] ? base : cur + DAW'(4);
          st  <= TX_OWN;
        end
        TX_SUSP: begin
          if (!run) st <= TX_IDLE;
          else if (poll) st <= TX_OWN;
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dring_rx.sv
module dring_rx
  import dring_pkg::*;
#(
  parameter int DAW   = 5,
  parameter int BAW   = 7,
  parameter int LEN_W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_rst,
  input  logic           run,
  input  logic [DAW-1:0] base,
  output logic [DAW-1:0] d_addr,
  input  logic [31:0]    d_rdata,
  output logic           d_we,
  output logic [31:0]    d_wdata,
  output logic           b_we,
  output logic [BAW-1:0] b_addr,
  output logic [7:0]     b_wdata,
  input  logic           rx_valid,
  output logic           rx_ready,
  input  logic [7:0]     rx_data,
  input  logic           rx_last,
  input  logic           rx_err,
  output logic [2:0]     code
);

  rx_st_e         st;
  logic [DAW-1:0] cur;
  logic [31:0]    ctrl;
  logic [BAW-1:0] baddr;
  logic [15:0]    cnt;
  logic           err;
  logic           accept;
  logic           fits;

  assign code     = rx_code(st);
  assign rx_ready = (st == RX_RECV);
  assign accept   = rx_valid && rx_ready;
  assign fits     = cnt < 16'(ctrl[LEN_W-1:0]);

  always_comb begin
    case (st)
      RX_CTRL: d_addr = cur + DAW'(1);
      RX_BUFA: d_addr = cur + DAW'(2);
      default: d_addr = cur;
    endcase
  end

  assign d_we    = (st == RX_CLOSE);
  assign d_wdata = rx_wb_word(cnt, err);
  assign b_we    = accept && fits;
  assign b_addr  = baddr + BAW'(cnt);
  assign b_wdata = rx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_IDLE; cur <= '0; ctrl <= '0; baddr <= '0; cnt <= '0; err <= 1'b0;
    end else if (soft_rst) begin
      st <= RX_IDLE; cur <= '0; ctrl <= '0; baddr <= '0; cnt <= '0; err <= 1'b0;
    end else begin
      case (st)
        RX_IDLE: if (run) begin st <= RX_OWN; cur <= base; end
        RX_OWN: begin
          if (!run) st <= RX_IDLE;
          else if (!d_rdata[OWN_B]) st <= RX_SUSP;
          else st <= RX_CTRL;
        end
        RX_SUSP: begin
          if (!run) st <= RX_IDLE;
          else if (d_rdata[OWN_B]) st <= RX_CTRL;
        end
        RX_CTRL: begin ctrl <= d_rdata; st <= RX_BUFA; end
        RX_BUFA: begin
          baddr <= d_rdata[BAW-1:0];
          cnt   <= '0;
          err   <= 1'b0;
          st    <= RX_RECV;
        end
        RX_RECV: begin
          if (accept) begin
            if (cnt != 16'hFFFF) cnt <= cnt + 16'd1;
            if (!fits || rx_err) err <= 1'b1;
            if (rx_last) st <= RX_CLOSE;
          end else if (!run && cnt == '0) begin
            st <= RX_IDLE;
          end
        end
        RX_CLOSE: begin
          cur <= ctrl[EOR_B] ? base : cur + DAW'(4);
          st  <= RX_OWN;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dring_dma.sv
module dring_dma
  import dring_pkg::*;
#(
  parameter int DESC_WORDS = 32,
  parameter int BUF_BYTES  = 128,
  parameter int LEN_W      = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [8:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_first,
  output logic        tx_last,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  input  logic        rx_err
);

  localparam int DAW = $clog2(DESC_WORDS);
  localparam int BAW = $clog2(BUF_BYTES);

  logic [1:0]     rgn;
  logic           h_dwe, h_bwe, h_rwe;
  logic [31:0]    h_drdata, h_rrdata;
  logic [7:0]     h_brdata;

  logic           soft_rst_w, tx_run_w, rx_run_w, tx_poll_w;
  logic [DAW-1:0] rx_base_w, tx_base_w;
  logic [2:0]     tx_code_w, rx_code_w;

  logic [DAW-1:0] tx_daddr, rx_daddr;
  logic [31:0]    tx_drdata, rx_drdata;
  logic           tx_wb_we, rx_wb_we;
  logic [31:0]    tx_wb_data, rx_wb_data;
  logic [BAW-1:0] tx_baddr, rx_baddr;
  logic [7:0]     tx_brdata, rx_bwdata;
  logic           rx_bwe;

  assign rgn   = host_addr[8:7];
  assign h_dwe = host_we && (rgn == RGN_DESC);
  assign h_bwe = host_we && (rgn == RGN_BUF);
  assign h_rwe = host_we && (rgn == RGN_REG);

  always_comb begin
    case (rgn)
      RGN_DESC: host_rdata = h_drdata;
      RGN_BUF:  host_rdata = {24'd0, h_brdata};
      RGN_REG:  host_rdata = h_rrdata;
      default:  host_rdata = '0;
    endcase
  end

  dring_regs #(.DAW(DAW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(h_rwe), .sel(host_addr[2:0]),
    .wdata(host_wdata), .txc(tx_code_w), .rxc(rx_code_w), .rdata(h_rrdata),
    .soft_rst(soft_rst_w), .tx_run(tx_run_w), .rx_run(rx_run_w),
    .tx_poll(tx_poll_w), .rx_base(rx_base_w), .tx_base(tx_base_w)
  );

  dring_mem #(.DESC_WORDS(DESC_WORDS), .BUF_BYTES(BUF_BYTES)) u_mem (
    .clk(clk),
    .h_dwe(h_dwe), .h_daddr(host_addr[DAW-1:0]), .h_dwdata(host_wdata),
    .h_drdata(h_drdata),
    .h_bwe(h_bwe), .h_baddr(host_addr[BAW-1:0]), .h_bwdata(host_wdata[7:0]),
    .h_brdata(h_brdata),
    .t_daddr(tx_daddr), .t_drdata(tx_drdata), .t_dwe(tx_wb_we),
    .t_dwdata(tx_wb_data), .t_baddr(tx_baddr), .t_brdata(tx_brdata),
    .r_daddr(rx_daddr), .r_drdata(rx_drdata), .r_dwe(rx_wb_we),
    .r_dwdata(rx_wb_data), .r_bwe(rx_bwe), .r_baddr(rx_baddr),
    .r_bwdata(rx_bwdata)
  );

  dring_tx #(.DAW(DAW), .BAW(BAW), .LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES)) u_tx (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst_w), .run(tx_run_w),
    .poll(tx_poll_w), .base(tx_base_w),
    .d_addr(tx_daddr), .d_rdata(tx_drdata), .d_we(tx_wb_we), .d_wdata(tx_wb_data),
    .b_addr(tx_baddr), .b_rdata(tx_brdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_first(tx_first), .tx_last(tx_last), .code(tx_code_w)
  );

  dring_rx #(.DAW(DAW), .BAW(BAW), .LEN_W(LEN_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst_w), .run(rx_run_w),
    .base(rx_base_w),
    .d_addr(rx_daddr), .d_rdata(rx_drdata), .d_we(rx_wb_we), .d_wdata(rx_wb_data),
    .b_we(rx_bwe), .b_addr(rx_baddr), .b_wdata(rx_bwdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_last(rx_last), .rx_err(rx_err), .code(rx_code_w)
  );

endmodule

// File: rtl/dring_chk.sv
module dring_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic [2:0]  tx_code,
  input logic [2:0]  rx_code,
  input logic        tx_poll,
  input logic        tx_run,
  input logic        tx_wb_we,
  input logic [31:0] tx_wb_data,
  input logic        rx_wb_we,
  input logic [31:0] rx_wb_data,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        tx_first,
  input logic        rx_ready
);

  p_swreset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (tx_code == 3'd0 && rx_code == 3'd0));

  p_tx_own_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wb_we |-> !tx_wb_data[31]);

  p_rx_own_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wb_we |-> !rx_wb_data[31]);

  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_tx_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_first |-> tx_valid);

  p_tx_suspend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_code == 3'd6 && tx_run && !tx_poll && !soft_rst) |=> (tx_code == 3'd6));

  p_rx_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wb_we |-> rx_wb_data[8]);

  p_rx_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_code == 3'd4) |-> !rx_ready);

  p_send_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_code == 3'd2));

endmodule

bind dring_dma dring_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst_w),
  .tx_code(tx_code_w), .rx_code(rx_code_w),
  .tx_poll(tx_poll_w), .tx_run(tx_run_w),
  .tx_wb_we(tx_wb_we), .tx_wb_data(tx_wb_data),
  .rx_wb_we(rx_wb_we), .rx_wb_data(rx_wb_data),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_first(tx_first), .rx_ready(rx_ready)
);

// File: tb/sim_dring_dma.sv
module sim_dring_dma;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [8:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        tx_valid, tx_first, tx_last;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b1;
  logic        rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;

  int checks = 0;
  int errors = 0;

  localparam logic [8:0] R_BUS = 9'h100, R_OPM = 9'h101, R_POLL = 9'h102,
                         R_RXB = 9'h103, R_TXB = 9'h104, R_STAT = 9'h105;
  localparam logic [8:0] BUFA = 9'h080;

  always #4 clk = ~clk;

  dring_dma u0 (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_first(tx_first), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_last(rx_last), .rx_err(rx_err)
  );

  // transmit stream capture and optional backpressure
  logic [7:0] cap_d [16];
  logic       cap_f [16];
  logic       cap_l [16];
  int         cap_n = 0;
  logic       bp = 1'b0;

  always @(negedge clk) begin
    if (tx_valid && tx_ready && cap_n < 16) begin
      cap_d[cap_n] = tx_data;
      cap_f[cap_n] = tx_first;
      cap_l[cap_n] = tx_last;
      cap_n = cap_n + 1;
    end
    tx_ready <= bp ? ~tx_ready : 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_we = 1'b0;
    #1 d = host_rdata;
  endtask

  task automatic set_desc(input int k, input logic [31:0] ctrl, input logic [31:0] ba,
                          input logic own);
    host_wr(9'(4*k+1), ctrl);
    host_wr(9'(4*k+2), ba);
    host_wr(9'(4*k), own ? 32'h8000_0000 : 32'h0);
  endtask

  task automatic wait_tx(input logic [2:0] c);
    logic [31:0] s;
    for (int i = 0; i < 300; i++) begin
      host_rd(R_STAT, s);
      if (s[22:20] == c) break;
    end
  endtask

  task automatic wait_rx(input logic [2:0] c);
    logic [31:0] s;
    for (int i = 0; i < 300; i++) begin
      host_rd(R_STAT, s);
      if (s[19:17] == c) break;
    end
  endtask

  task automatic rx_frame(input int n, input logic [7:0] b0, input logic errlast);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1;
      rx_data  = b0 + 8'(i);
      rx_last  = (i == n - 1);
      rx_err   = errlast && (i == n - 1);
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    host_rd(R_STAT, d); chk("R1 status after reset", d, 32'h0);
    host_rd(R_OPM, d);  chk("R1 opmode after reset", d, 32'h0);
  endtask

  task automatic t_tx_basic;
    logic [31:0] d;
    for (int i = 0; i < 5; i++) host_wr(BUFA + 9'(i), 32'hA0 + i);
    set_desc(0, 32'h6000_0005, 32'd0, 1'b1);
    host_wr(9'd4, 32'h0);
    host_wr(R_TXB, 32'd0);
    cap_n = 0; bp = 1'b1;
    host_wr(R_OPM, 32'h0000_2000);
    wait_tx(3'd6);
    bp = 1'b0;
    chk("R3 byte count", 32'(cap_n), 32'd5);
    for (int i = 0; i < 5; i++) begin
      chk("R3 byte value", {24'd0, cap_d[i]}, 32'hA0 + i);
      chk("R3 first marker", {31'd0, cap_f[i]}, {31'd0, i == 0});
      chk("R3 last marker", {31'd0, cap_l[i]}, {31'd0, i == 4});
    end
    host_rd(9'd0, d); chk("R2 tx status own cleared", d, 32'h0);
    host_rd(R_STAT, d); chk("R12 tx suspended code", d, 32'h0060_0000);
  endtask

  task automatic t_tx_poll_wrap;
    logic [31:0] d;
    host_wr(BUFA + 9'd8, 32'h11); host_wr(BUFA + 9'd9, 32'h22);
    host_wr(BUFA + 9'd20, 32'h5A);
    set_desc(1, 32'h6200_0002, 32'd8, 1'b1);
    set_desc(0, 32'h6000_0001, 32'd20, 1'b1);
    cap_n = 0;
    repeat (20) @(negedge clk);
    chk("R6 no progress without poll", 32'(cap_n), 32'd0);
    host_wr(R_POLL, 32'h1);
    wait_tx(3'd6);
    chk("R6 bytes after poll", 32'(cap_n), 32'd3);
    chk("R7 wrap sends desc0 after end-of-ring", {24'd0, cap_d[2]}, 32'h5A);
    chk("R3 byte order", {24'd0, cap_d[1]}, 32'h22);
    host_rd(9'd4, d); chk("R2 desc1 status", d, 32'h0);
  endtask

  task automatic t_tx_err_setup;
    logic [31:0] d;
    cap_n = 0;
    set_desc(1, 32'h6200_0000, 32'd0, 1'b1);
    host_wr(R_POLL, 32'h1); wait_tx(3'd6);
    host_rd(9'd4, d); chk("R4 zero length error status", d, 32'h0000_8000);
    set_desc(0, 32'h6200_00C8, 32'd0, 1'b1);
    host_wr(R_POLL, 32'h1); wait_tx(3'd6);
    host_rd(9'd0, d); chk("R4 oversize error status", d, 32'h0000_8000);
    chk("R4 no bytes sent", 32'(cap_n), 32'd0);
    set_desc(0, 32'h0A00_00C0, 32'd0, 1'b1);
    host_wr(R_POLL, 32'h1); wait_tx(3'd6);
    host_rd(9'd0, d); chk("R5 setup status", d, 32'h0);
    chk("R5 setup sends nothing", 32'(cap_n), 32'd0);
  endtask

  task automatic t_rx_basic;
    logic [31:0] d;
    set_desc(4, 32'h0000_0020, 32'd64, 1'b1);
    host_wr(9'd20, 32'h0);
    host_wr(R_RXB, 32'd16);
    host_wr(R_OPM, 32'h0000_2002);
    rx_frame(6, 8'hC0, 1'b0);
    wait_rx(3'd4);
    host_rd(9'd16, d); chk("R8 rx write-back", d, 32'h0006_0100);
    for (int i = 0; i < 6; i++) begin
      host_rd(BUFA + 9'(64 + i), d); chk("R8 rx byte stored", d, 32'hC0 + i);
    end
  endtask

  task automatic t_rx_stall_ovf;
    logic [31:0] d;
    host_wr(BUFA + 9'd82, 32'hEE);
    fork
      rx_frame(3, 8'h31, 1'b0);
      begin
        repeat (10) @(negedge clk);
        chk("R10 rx_ready low while stalled", {31'd0, rx_ready}, 32'd0);
        host_rd(R_STAT, d); chk("R10 rx suspended code", {29'd0, d[19:17]}, 32'd4);
        set_desc(5, 32'h0200_0002, 32'd80, 1'b1);
      end
    join
    wait_rx(3'd4);
    host_rd(9'd20, d); chk("R9 overflow write-back", d, 32'h0003_8100);
    host_rd(BUFA + 9'd81, d); chk("R9 byte within capacity", d, 32'h32);
    host_rd(BUFA + 9'd82, d); chk("R9 byte beyond capacity dropped", d, 32'hEE);
  endtask

  task automatic t_rx_err;
    logic [31:0] d;
    host_wr(9'd16, 32'h8000_0000);
    rx_frame(2, 8'h41, 1'b1);
    wait_rx(3'd4);
    host_rd(9'd16, d); chk("R8 rx error summary", d, 32'h0002_8100);
  endtask

  task automatic t_stop_reset;
    logic [31:0] d;
    host_wr(R_OPM, 32'h0000_2000);
    repeat (4) @(negedge clk);
    host_rd(R_STAT, d); chk("R11 rx stopped, tx still suspended", d, 32'h0060_0000);
    host_wr(R_OPM, 32'h0);
    repeat (4) @(negedge clk);
    host_rd(R_STAT, d); chk("R11 both stopped", d, 32'h0);
    host_wr(R_OPM, 32'h0000_2002);
    repeat (10) @(negedge clk);
    host_rd(R_STAT, d); chk("R11 restart at ring bases", d, 32'h0068_0000);
    host_wr(R_BUS, 32'h1);
    host_rd(R_STAT, d); chk("R1 status after software reset", d, 32'h0);
    host_rd(R_OPM, d);  chk("R1 opmode after software reset", d, 32'h0);
    host_rd(R_RXB, d);  chk("R1 rx base after software reset", d, 32'h0);
    host_rd(9'd20, d);  chk("R1 descriptors kept", d, 32'h0003_8100);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx_basic();
    t_tx_poll_wrap();
    t_tx_err_setup();
    t_rx_basic();
    t_rx_stall_ovf();
    t_rx_err();
    t_stop_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule